// File: doc/BRIEF.md
# Fixed-Point Add Unit with Condition Codes

This unit performs one 32-bit two's complement addition or subtraction for each accepted request. The left operand is always the contents of register R. The right operand comes from one of three sources: a 20-bit immediate field taken from the low bits of the instruction word, a 16-bit halfword fetched from memory, or a second register word. Immediate and halfword operands are sign-extended to the full word width. For subtraction the right operand is inverted and a carry-in of one is added.

One cycle after a request is accepted, the unit presents the result and a write strobe for register R. It also presents a four-bit condition code made of carry, signed overflow and a two-bit class for the result: zero, positive or negative. An overflowing result is still written. When the arithmetic trap mask is set, an overflow also raises a trap request to the overflow vector. An illegal encoding raises a trap request to the illegal-instruction vector instead. In that case the write strobe stays low and the held condition code is left unchanged. The unit keeps the condition code as state, so an illegal request shows the code left by the previous operation.

Top module: `fxadd_unit`

## Requirements
- R1: In immediate mode (src_sel = 0) the addend is instr[19:0] sign-extended from instr[19]. instr[30:20] have no effect on the result.
- R2: In halfword mode (src_sel = 1) the addend is half_op[15:0] sign-extended from half_op[15]. In register mode (src_sel = 2) the addend is reg_b.
- R3: cc[3] is the carry out of bit 31 of reg_a + addend for an add (sub = 0), or of reg_a + ~addend + 1 for a subtract (sub = 1). A subtract of zero therefore always gives cc[3] = 1.
- R4: cc[2] is 1 exactly when the signed result overflows. The wrapped 32-bit sum is still delivered on result with reg_we = 1.
- R5: cc[1:0] classifies the written result: 2'b00 means zero, 2'b10 means positive, 2'b01 means negative.
- R6: For a legal request with cc[2] = 1 and trap_mask = 1, trap_req = 1 with trap_addr = 8'h43 in the same cycle as reg_we = 1. A legal request without that combination gives trap_req = 0.
- R7: An immediate-mode request with indirect = 1 or instr[31] = 1 is illegal, and so is any request with src_sel = 3. An illegal request gives trap_req = 1 with trap_addr = 8'h40 and reg_we = 0. cc holds its previous value and result equals reg_a. An illegal request never raises the overflow trap.
- R8: in_ready is 1. The outputs of a request accepted at a clock edge appear after that edge for exactly one cycle, with out_valid = 1. reg_we and trap_req are 0 whenever out_valid is 0.
- R9: After reset, out_valid, reg_we and trap_req are 0, and cc is 4'b0000.
- R10: When reg_b equals reg_a in register mode, doubling the word gives the correct sum, carry, overflow and class, including the case 0x80000000 + 0x80000000.

Top module ports, in port-list order:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can accept a request (always 1) |
| src_sel | input | 2 | Operand source: 0 immediate, 1 halfword, 2 register, 3 illegal |
| sub | input | 1 | 1 selects subtraction |
| indirect | input | 1 | Indirect-addressing flag of the instruction |
| trap_mask | input | 1 | Arithmetic trap mask |
| instr | input | 32 | Instruction word; bit 31 is the most significant (leftmost) bit |
| reg_a | input | 32 | Contents of register R |
| reg_b | input | 32 | Second register operand |
| half_op | input | 16 | Halfword operand from memory |
| out_valid | output | 1 | Result of an accepted request is present |
| result | output | 32 | Sum or difference, or reg_a for an illegal request |
| reg_we | output | 1 | Write strobe for register R |
| cc | output | 4 | Condition code {carry, overflow, positive, negative} |
| trap_req | output | 1 | Trap request |
| trap_addr | output | 8 | Trap vector: 8'h43 for overflow, 8'h40 for illegal |

## Verification
Two pairs of functions can occur in the same output cycle. A register write can coincide with the overflow trap. An illegal encoding can coincide with operands whose sum would overflow while the mask is set. The bench provokes the first pair with signed-overflowing additions and subtractions under a set mask. It passes only if the wrapped sum is written while vector 0x43 is requested. It provokes the second pair with indirect, sign-bit and reserved-source immediates on an overflowing reg_a. It judges that vector 0x40 wins, that nothing is written, and that the condition code is unchanged from the preceding legal operation.

// File: rtl/fxadd_pkg.sv
package fxadd_pkg;

  typedef enum logic [1:0] {
    SRC_IMM  = 2'd0,
    SRC_HALF = 2'd1,
    SRC_REG  = 2'd2,
    SRC_BAD  = 2'd3
  } src_e;

  // Result class bits {positive, negative}; both clear means zero.
  function automatic logic [1:0] class_bits(input logic neg, input logic zero);
    if (zero)     class_bits = 2'b00;
    else if (neg) class_bits = 2'b01;
    else          class_bits = 2'b10;
  endfunction

endpackage

// File: rtl/fxadd_operand.sv
module fxadd_operand #(
  parameter int W      = 32,
  parameter int IMM_W  = 20,
  parameter int HALF_W = 16
) (
  input  logic [1:0]        src_sel,
  input  logic [IMM_W-1:0]  imm_field,
  input  logic [HALF_W-1:0] half_op,
  input  logic [W-1:0]      reg_b,
  output logic [W-1:0]      addend
);
  import fxadd_pkg::*;

  function automatic logic [W-1:0] sext_imm(input logic [IMM_W-1:0] v);
    sext_imm = {{(W-IMM_W){v[IMM_W-1]}}, v};
  endfunction

  function automatic logic [W-1:0] sext_half(input logic [HALF_W-1:0] v);
    sext_half = {{(W-HALF_W){v[HALF_W-1]}}, v};
  endfunction

  always_comb begin
    unique case (src_e'(src_sel))
      SRC_IMM:  addend = sext_imm(imm_field);
      SRC_HALF: addend = sext_half(half_op);
      SRC_REG:  addend = reg_b;
      default:  addend = '0;
    endcase
  end

  // R1 / R2: the upper bits of the extended operand all equal its sign bit
  always_comb begin
    if (src_sel == SRC_IMM)
      a_r1_imm_sext: assert (addend[W-1:IMM_W] == {(W-IMM_W){imm_field[IMM_W-1]}});
    if (src_sel == SRC_HALF)
      a_r2_half_sext: assert (addend[W-1:HALF_W] == {(W-HALF_W){half_op[HALF_W-1]}});
  end

endmodule

// File: rtl/fxadd_core.sv
module fxadd_core #(
  parameter int W = 32
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         carry_out,
  output logic         overflow,
  output logic [1:0]   cls
);
  import fxadd_pkg::*;

  logic [W-1:0] b_eff;
  logic [W-1:0] low_part;
  logic [1:0]   msb_part;
  logic         carry_into_msb;

  assign b_eff = sub ? ~op_b : op_b;

  // split the adder so the carry into the sign position is visible
  assign low_part = {1'b0, op_a[W-2:0]} + {1'b0, b_eff[W-2:0]} + {{(W-1){1'b0}}, sub};
  assign carry_into_msb = low_part[W-1];
  assign msb_part = {1'b0, op_a[W-1]} + {1'b0, b_eff[W-1]} + {1'b0, carry_into_msb};

  assign sum       = {msb_part[0], low_part[W-2:0]};
  assign carry_out = msb_part[1];
  assign overflow  = carry_into_msb ^ carry_out;
  assign cls       = class_bits(sum[W-1], sum == '0);

  always_comb begin
    if (!$isunknown({op_a, op_b, sub})) begin
      // R4: overflow matches the operand/result sign rule
      a_r4_ovf_by_signs: assert (overflow ==
        ((op_a[W-1] == b_eff[W-1]) && (sum[W-1] != op_a[W-1])));
      // R3: subtracting zero always carries
      a_r3_sub_zero_carry: assert (!(sub && op_b == '0) || carry_out);
      // R5: zero class exactly for an all-zero sum
      a_r5_zero_class: assert ((cls == 2'b00) == (sum == '0));
    end
  end

endmodule

// File: rtl/fxadd_trap.sv
module fxadd_trap #(
  parameter logic [7:0] TRAP_ILLEGAL = 8'h40,
  parameter logic [7:0] TRAP_OVF     = 8'h43
) (
  input  logic [1:0] src_sel,
  input  logic       indirect,
  input  logic       instr_msb,
  input  logic       overflow,
  input  logic       trap_mask,
  output logic       illegal,
  output logic       ovf_trap,
  output logic       trap_req,
  output logic [7:0] trap_addr
);
  import fxadd_pkg::*;

  assign illegal  = (src_sel == SRC_BAD) ||
                    ((src_sel == SRC_IMM) && (indirect || instr_msb));
  assign ovf_trap = !illegal && overflow && trap_mask;
  assign trap_req = illegal || ovf_trap;
  assign trap_addr = illegal  ? TRAP_ILLEGAL :
                     ovf_trap ? TRAP_OVF : 8'h00;

endmodule

// File: rtl/fxadd_unit.sv
module fxadd_unit #(
  parameter int         W            = 32,
  parameter int         IMM_W        = 20,
  parameter int         HALF_W       = 16,
  parameter logic [7:0] TRAP_ILLEGAL = 8'h40,
  parameter logic [7:0] TRAP_OVF     = 8'h43
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        src_sel,
  input  logic              sub,
  input  logic              indirect,
  input  logic              trap_mask,
  input  logic [W-1:0]      instr,
  input  logic [W-1:0]      reg_a,
  input  logic [W-1:0]      reg_b,
  input  logic [HALF_W-1:0] half_op,
  output logic              out_valid,
  output logic [W-1:0]      result,
  output logic              reg_we,
  output logic [3:0]        cc,
  output logic              trap_req,
  output logic [7:0]        trap_addr
);

  logic [W-1:0] addend;
  logic [W-1:0] sum;
  logic         carry_out;
  logic         overflow;
  logic [1:0]   cls;
  logic         illegal;
  logic         ovf_trap;
  logic         trap_now;
  logic [7:0]   trap_addr_now;
  logic         mask_q;
  logic         accept;

  wire unused_instr_mid = ^instr[W-2:IMM_W];

  assign in_ready = 1'b1;
  assign accept   = in_valid && in_ready;

  fxadd_operand #(.W(W), .IMM_W(IMM_W), .HALF_W(HALF_W)) u_operand (
    .src_sel   (src_sel),
    .imm_field (instr[IMM_W-1:0]),
    .half_op   (half_op),
    .reg_b     (reg_b),
    .addend    (addend)
  );

  fxadd_core #(.W(W)) u_core (
    .op_a      (reg_a),
    .op_b      (addend),
    .sub       (sub),
    .sum       (sum),
    .carry_out (carry_out),
    .overflow  (overflow),
    .cls       (cls)
  );

  fxadd_trap #(.TRAP_ILLEGAL(TRAP_ILLEGAL), .TRAP_OVF(TRAP_OVF)) u_trap (
    .src_sel   (src_sel),
    .indirect  (indirect),
    .instr_msb (instr[W-1]),
    .overflow  (overflow),
    .trap_mask (trap_mask),
    .illegal   (illegal),
    .ovf_trap  (ovf_trap),
    .trap_req  (trap_now),
    .trap_addr (trap_addr_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      reg_we    <= 1'b0;
      cc        <= 4'b0000;
      trap_req  <= 1'b0;
      trap_addr <= 8'h00;
      mask_q    <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      result    <= illegal ? reg_a : sum;
      reg_we    <= !illegal;
      if (!illegal) cc <= {carry_out, overflow, cls};
      trap_req  <= trap_now;
      trap_addr <= trap_addr_now;
      mask_q    <= trap_mask;
    end else begin
      out_valid <= 1'b0;
      reg_we    <= 1'b0;
      trap_req  <= 1'b0;
    end
  end

  // R8: strobes only alongside a valid output
  a_r8_we_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> out_valid);
  a_r8_trap_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> out_valid);
  a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R7: illegal leaves the condition code and register alone
  a_r7_illegal_holds_cc: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && trap_req && trap_addr == TRAP_ILLEGAL) |-> ($stable(cc) && !reg_we));
  // R6: masked overflow on a write raises the overflow vector
  a_r6_ovf_trap_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && reg_we && cc[2] && mask_q) |-> (trap_req && trap_addr == TRAP_OVF));
  a_r6_no_trap_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && reg_we && !cc[2]) |-> !trap_req);

endmodule

// File: tb/fxadd_unit_test.sv
module fxadd_unit_test;

  typedef struct packed {
    logic [1:0]  src;
    logic        sub;
    logic        mask;
    logic        ind;
    logic [31:0] instr;
    logic [31:0] ra;
    logic [31:0] rb;
    logic [15:0] hw;
    logic [31:0] er;
    logic [3:0]  ecc;
    logic        ewe;
    logic        etrap;
    logic [7:0]  eaddr;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    // R1 small positive immediate
    '{2'd0, 1'b0, 1'b0, 1'b0, 32'h0000_0005, 32'h0000_0010, 32'h0, 16'h0, 32'h0000_0015, 4'b0010, 1'b1, 1'b0, 8'h00, 4'd1},
    // R3 immediate -1 carries out
    '{2'd0, 1'b0, 1'b0, 1'b0, 32'h000F_FFFF, 32'h0000_0003, 32'h0, 16'h0, 32'h0000_0002, 4'b1010, 1'b1, 1'b0, 8'h00, 4'd3},
    // R1 bits 30..20 ignored, negative field, zero result
    '{2'd0, 1'b0, 1'b0, 1'b0, 32'h7FF8_0000, 32'h0008_0000, 32'h0, 16'h0, 32'h0000_0000, 4'b1000, 1'b1, 1'b0, 8'h00, 4'd1},
    // R2 negative halfword
    '{2'd1, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0000_1000, 32'h0, 16'h8000, 32'hFFFF_9000, 4'b0001, 1'b1, 1'b0, 8'h00, 4'd2},
    // R3 subtract zero sets carry
    '{2'd1, 1'b1, 1'b0, 1'b0, 32'h0, 32'h1234_5678, 32'h0, 16'h0000, 32'h1234_5678, 4'b1010, 1'b1, 1'b0, 8'h00, 4'd3},
    // R4 overflow, mask clear: written, no trap
    '{2'd2, 1'b0, 1'b0, 1'b0, 32'h0, 32'h7FFF_FFFF, 32'h1, 16'h0, 32'h8000_0000, 4'b0101, 1'b1, 1'b0, 8'h00, 4'd4},
    // R6 overflow, mask set: written and trap 43
    '{2'd2, 1'b0, 1'b1, 1'b0, 32'h0, 32'h7FFF_FFFF, 32'h1, 16'h0, 32'h8000_0000, 4'b0101, 1'b1, 1'b1, 8'h43, 4'd6},
    // R10 doubling negative, no overflow
    '{2'd2, 1'b0, 1'b0, 1'b0, 32'h0, 32'hC000_0000, 32'hC000_0000, 16'h0, 32'h8000_0000, 4'b1001, 1'b1, 1'b0, 8'h00, 4'd10},
    // R10 doubling min value: zero, carry, overflow, trap
    '{2'd2, 1'b0, 1'b1, 1'b0, 32'h0, 32'h8000_0000, 32'h8000_0000, 16'h0, 32'h0000_0000, 4'b1100, 1'b1, 1'b1, 8'h43, 4'd10},
    // R5 negative difference, no carry
    '{2'd2, 1'b1, 1'b0, 1'b0, 32'h0, 32'h0000_0005, 32'h7, 16'h0, 32'hFFFF_FFFE, 4'b0001, 1'b1, 1'b0, 8'h00, 4'd5},
    // R4 subtract overflow
    '{2'd2, 1'b1, 1'b0, 1'b0, 32'h0, 32'h8000_0000, 32'h1, 16'h0, 32'h7FFF_FFFF, 4'b1110, 1'b1, 1'b0, 8'h00, 4'd4},
    // R7 indirect immediate: trap 40, cc held
    '{2'd0, 1'b0, 1'b1, 1'b1, 32'h0000_0001, 32'h7FFF_FFFF, 32'h0, 16'h0, 32'h7FFF_FFFF, 4'b1110, 1'b0, 1'b1, 8'h40, 4'd7},
    // R7 instruction bit 31 set
    '{2'd0, 1'b0, 1'b1, 1'b0, 32'h8000_0001, 32'h7FFF_FFFF, 32'h0, 16'h0, 32'h7FFF_FFFF, 4'b1110, 1'b0, 1'b1, 8'h40, 4'd7},
    // R7 reserved source
    '{2'd3, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0000_0055, 32'h1, 16'h0, 32'h0000_0055, 4'b1110, 1'b0, 1'b1, 8'h40, 4'd7},
    // R5 zero plus zero
    '{2'd0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0, 16'h0, 32'h0, 4'b0000, 1'b1, 1'b0, 8'h00, 4'd5},
    // R2 positive halfword into sign bit 15 of result only
    '{2'd1, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0000_0001, 32'h0, 16'h7FFF, 32'h0000_8000, 4'b0010, 1'b1, 1'b0, 8'h00, 4'd2}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  src_sel = 2'd0;
  logic        sub = 1'b0;
  logic        indirect = 1'b0;
  logic        trap_mask = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] reg_a = '0;
  logic [31:0] reg_b = '0;
  logic [15:0] half_op = '0;
  logic        out_valid;
  logic [31:0] result;
  logic        reg_we;
  logic [3:0]  cc;
  logic        trap_req;
  logic [7:0]  trap_addr;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  fxadd_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .src_sel(src_sel), .sub(sub), .indirect(indirect), .trap_mask(trap_mask),
    .instr(instr), .reg_a(reg_a), .reg_b(reg_b), .half_op(half_op),
    .out_valid(out_valid), .result(result), .reg_we(reg_we), .cc(cc),
    .trap_req(trap_req), .trap_addr(trap_addr)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 reset", {in_ready, out_valid, reg_we, trap_req, cc}, {1'b1, 1'b0, 1'b0, 1'b0, 4'b0000});
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      src_sel   = VEC[i].src;
      sub       = VEC[i].sub;
      trap_mask = VEC[i].mask;
      indirect  = VEC[i].ind;
      instr     = VEC[i].instr;
      reg_a     = VEC[i].ra;
      reg_b     = VEC[i].rb;
      half_op   = VEC[i].hw;
      in_valid  = 1'b1;
      @(negedge clk);
      in_valid  = 1'b0;
      check($sformatf("R%0d vector %0d", VEC[i].req, i),
            {out_valid, result, cc, reg_we, trap_req, trap_addr},
            {1'b1, VEC[i].er, VEC[i].ecc, VEC[i].ewe, VEC[i].etrap, VEC[i].eaddr});
    end

    // R8 output lasts one cycle only
    @(negedge clk);
    check("R8 idle after pulse", {out_valid, reg_we, trap_req}, 3'b000);

    // R8 back-to-back requests each give their own result
    src_sel = 2'd2; sub = 1'b0; trap_mask = 1'b1; indirect = 1'b0;
    reg_a = 32'h0000_0002; reg_b = 32'h0000_0003; in_valid = 1'b1;
    @(negedge clk);
    check("R8 first of pair", {out_valid, result, cc}, {1'b1, 32'h0000_0005, 4'b0010});
    reg_a = 32'hFFFF_FFFF; reg_b = 32'h0000_0001;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 second of pair", {out_valid, result, cc, trap_req}, {1'b1, 32'h0, 4'b1000, 1'b0});

    // R9 reset clears held condition code
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 reset clears cc", {out_valid, reg_we, trap_req, cc}, {3'b000, 4'b0000});
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule